// File: doc/BRIEF.md
# UDP receive header parser

This block sits on top of an IPv4 receive layer. Once the IP header of a packet has been decoded, the IP layer raises a packet strobe and presents a small header bundle: a valid flag, the protocol number and the source address. After that, the IP payload arrives as a byte stream with valid and last flags. The parser looks at the protocol number. If it is UDP, the parser reads the eight-byte UDP header from the front of the stream. It then presents the ports, the payload length and the source address as header outputs, and forwards every remaining byte as payload.

Any other protocol number makes the parser drop the whole packet without a trace on its outputs, up to and including the last byte. A packet whose stream ends inside the UDP header is dropped the same way. Checksum bytes are read past and not checked.

Every output is registered, so each payload byte appears one cycle after it is sampled. The parser takes a new packet only after the packet strobe has been seen low, which also clears the header outputs.

Top module: `udp_rx_parser`

## Requirements
- R1: While reset is asserted and after it is released, udp_start, udp_hdr_valid, udp_data_valid and udp_data_last are 0 and udp_data is 0x00.
- R2: A packet is accepted as UDP only when ip_start and ip_hdr_valid are both high in idle and ip_proto equals 0x11. With any other protocol value, udp_hdr_valid, udp_start, udp_data_valid and udp_data_last stay 0 for the whole packet.
- R3: The first eight stream bytes are the UDP header, each field sent most significant byte first. Bytes 0-1 are the source port and bytes 2-3 the destination port. Bytes 4-5 hold the UDP length, which includes the header. Bytes 6-7 are the checksum, which is consumed and not checked.
- R4: udp_pay_len is the UDP length field minus 8, or 0 when the field is below 8. The IP-layer length plays no part.
- R5: udp_hdr_valid goes high in the cycle after the eighth header byte is sampled. It stays high through the payload and clears in the cycle after ip_start is sampled low. It is 0 after a new packet is accepted.
- R6: udp_src_addr equals the ip_src_addr sampled when the packet was accepted.
- R7: A payload byte sampled with ip_data_valid appears on udp_data with udp_data_valid high in the next cycle. udp_start goes high with the first payload byte and stays high, through gaps, until the packet ends.
- R8: udp_data_last equals ip_data_last for each forwarded payload byte.
- R9: In the cycle after the last payload byte is shown, udp_data is 0x00 and udp_data_valid and udp_data_last are 0.
- R10: If ip_data_last arrives on header bytes 0 to 6, the packet is dropped and no output is asserted. If it arrives on byte 7, udp_hdr_valid rises and no payload follows.
- R11: ip_start sampled low ends any packet, including in mid-payload. All outputs are low one cycle later, and the next packet, UDP or not, is accepted normally.
- R12: Stream cycles with ip_data_valid low are skipped. They produce no output byte and do not disturb the header count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ip_start | input | 1 | High for the duration of an IP packet |
| ip_hdr_valid | input | 1 | IP header bundle valid |
| ip_proto | input | 8 | IP protocol number |
| ip_src_addr | input | 32 | IP source address |
| ip_data | input | 8 | IP payload byte |
| ip_data_valid | input | 1 | ip_data carries a byte |
| ip_data_last | input | 1 | Byte is the final one of the packet |
| udp_start | output | 1 | UDP payload delivery in progress |
| udp_hdr_valid | output | 1 | UDP header outputs are valid |
| udp_src_port | output | 16 | UDP source port |
| udp_dst_port | output | 16 | UDP destination port |
| udp_pay_len | output | 16 | UDP payload length in bytes |
| udp_src_addr | output | 32 | Source IP address of the packet |
| udp_data | output | 8 | Payload byte |
| udp_data_valid | output | 1 | udp_data carries a byte |
| udp_data_last | output | 1 | Final payload byte |

## Verification
Some state faults show up in the cycle after the byte concerned. A header counter that slips by one shifts every port field and moves the rise of udp_hdr_valid one byte away. It also lets a header byte leak out as payload. A protocol decision that goes the wrong way exposes a dropped packet's bytes on udp_data_valid at its first payload byte.

Other faults show up at the end of a packet. An end-of-packet state that does not wait for ip_start to fall leaves udp_start or udp_hdr_valid high one cycle too long. It can also make the next packet's header bytes go uncounted. Random packets with random gaps, protocols and length fields drive these paths, and every byte and every end of packet is compared against values the bench works out for itself.

// File: rtl/udp_rx_pkg.sv
`timescale 1ns/1ps
package udp_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR  = 3'd1,
    ST_PAY  = 3'd2,
    ST_DROP = 3'd3,
    ST_DONE = 3'd4
  } rx_state_t;

  localparam logic [7:0] PROTO_UDP = 8'h11;
endpackage

// File: rtl/udp_rx_rst_sync.sv
`timescale 1ns/1ps
module udp_rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/udp_rx_ctrl.sv
`timescale 1ns/1ps
module udp_rx_ctrl
  import udp_rx_pkg::*;
#(
  parameter int                 PROTO_W      = 8,
  parameter logic [PROTO_W-1:0] ACCEPT_PROTO = PROTO_W'(8'h11)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_start,
  input  logic               pkt_hdr_ok,
  input  logic [PROTO_W-1:0] pkt_proto,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic               hdr_final,
  output rx_state_t          state_q,
  output logic               accept_udp,
  output logic               hdr_byte_en,
  output logic               pay_en,
  output logic               pay_hold,
  output logic               hdr_clr
);
  rx_state_t state_d;
  logic      accept_any;

  always_comb begin
    accept_any  = (state_q == ST_IDLE) && pkt_start && pkt_hdr_ok;
    accept_udp  = accept_any && (pkt_proto == ACCEPT_PROTO);
    hdr_byte_en = (state_q == ST_HDR) && pkt_start && in_valid;
    pay_en      = (state_q == ST_PAY) && pkt_start && in_valid;
    pay_hold    = (state_q == ST_PAY) && pkt_start;
    hdr_clr     = (state_q == ST_IDLE) || !pkt_start;
  end

  always_comb begin
    state_d = state_q;
    if (state_q != ST_IDLE && !pkt_start) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_udp)      state_d = ST_HDR;
          else if (accept_any) state_d = ST_DROP;
        end
        ST_HDR: begin
          if (in_valid) begin
            if (in_last)        state_d = ST_DONE;
            else if (hdr_final) state_d = ST_PAY;
          end
        end
        ST_PAY:  if (in_valid && in_last) state_d = ST_DONE;
        ST_DROP: if (in_valid && in_last) state_d = ST_DONE;
        ST_DONE: state_d = ST_DONE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R11: a finished packet waits for the strobe to fall before re-arming
  p_done_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && pkt_start) |=> (state_q == ST_DONE));

  // R2: a rejected packet stays in drop until its last byte or an abort
  p_drop_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP && pkt_start && !(in_valid && in_last)) |=> (state_q == ST_DROP));
endmodule

// File: rtl/udp_rx_hdr_cap.sv
`timescale 1ns/1ps
module udp_rx_hdr_cap #(
  parameter int DW        = 8,
  parameter int AW        = 32,
  parameter int HDR_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_src,
  input  logic [AW-1:0] src_in,
  input  logic          byte_en,
  input  logic [DW-1:0] byte_in,
  input  logic          clr,
  output logic          hdr_final,
  output logic          hdr_valid,
  output logic [2*DW-1:0] src_port,
  output logic [2*DW-1:0] dst_port,
  output logic [2*DW-1:0] pay_len,
  output logic [AW-1:0] src_addr
);
  localparam int             CW      = $clog2(HDR_BYTES);
  localparam int             PW      = 2 * DW;
  localparam int             KEEP    = 6;
  localparam logic [PW-1:0]  HDR_LEN = PW'(HDR_BYTES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          valid_d;
  logic [AW-1:0] src_d;
  logic [PW-1:0] udp_len;

  // header byte slots for ports and length; checksum bytes are only counted
  for (genvar g = 0; g < KEEP; g++) begin : g_slot
    logic          wr;
    logic [DW-1:0] q;
    assign wr = byte_en && (cnt_q == CW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= byte_in;
    end
  end

  assign hdr_final = (cnt_q == CW'(HDR_BYTES - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (load_src)     cnt_d = '0;
    else if (byte_en) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    valid_d = hdr_valid;
    if (clr)                       valid_d = 1'b0;
    else if (byte_en && hdr_final) valid_d = 1'b1;
  end

  assign src_d = load_src ? src_in : src_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      hdr_valid <= 1'b0;
      src_addr  <= '0;
    end else begin
      cnt_q     <= cnt_d;
      hdr_valid <= valid_d;
      src_addr  <= src_d;
    end
  end

  assign src_port = {g_slot[0].q, g_slot[1].q};
  assign dst_port = {g_slot[2].q, g_slot[3].q};
  assign udp_len  = {g_slot[4].q, g_slot[5].q};
  assign pay_len  = (udp_len > HDR_LEN) ? (udp_len - HDR_LEN) : '0;

  // R6: the captured address does not move while the header is shown
  p_src_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !load_src) |=> $stable(src_addr));

  // R3: header fields are frozen once the header is complete
  p_ports_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !clr) |=> ($stable(src_port) && $stable(dst_port) && $stable(pay_len)));
endmodule

// File: rtl/udp_rx_fwd.sv
`timescale 1ns/1ps
module udp_rx_fwd #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pay_en,
  input  logic          pay_hold,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_last,
  output logic          out_start
);
  logic [DW-1:0] data_d;
  logic          valid_d, last_d, start_d;

  always_comb begin
    valid_d = pay_en;
    data_d  = pay_en ? in_data : '0;
    last_d  = pay_en && in_last;
    start_d = pay_en || (out_start && pay_hold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_start <= 1'b0;
    end else begin
      out_data  <= data_d;
      out_valid <= valid_d;
      out_last  <= last_d;
      out_start <= start_d;
    end
  end

  // R8: last is only ever flagged on a delivered byte
  p_last_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R9: idle output bus reads zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

  // R9: nothing follows the last byte in the next cycle
  p_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (!out_valid && !out_last));

  // R7: every delivered byte is inside an active delivery
  p_valid_in_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_start);
endmodule

// File: rtl/udp_rx_parser.sv
`timescale 1ns/1ps
module udp_rx_parser
  import udp_rx_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 32,
  parameter int PROTO_W   = 8,
  parameter int HDR_BYTES = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ip_start,
  input  logic               ip_hdr_valid,
  input  logic [PROTO_W-1:0] ip_proto,
  input  logic [AW-1:0]      ip_src_addr,
  input  logic [DW-1:0]      ip_data,
  input  logic               ip_data_valid,
  input  logic               ip_data_last,
  output logic               udp_start,
  output logic               udp_hdr_valid,
  output logic [2*DW-1:0]    udp_src_port,
  output logic [2*DW-1:0]    udp_dst_port,
  output logic [2*DW-1:0]    udp_pay_len,
  output logic [AW-1:0]      udp_src_addr,
  output logic [DW-1:0]      udp_data,
  output logic               udp_data_valid,
  output logic               udp_data_last
);
  logic      rst_sync_n;
  rx_state_t state;
  logic      accept_udp, hdr_byte_en, pay_en, pay_hold, hdr_clr, hdr_final;

  udp_rx_rst_sync #(.STAGES(SYNC_STG)) i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  udp_rx_ctrl #(
    .PROTO_W      (PROTO_W),
    .ACCEPT_PROTO (PROTO_W'(PROTO_UDP))
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .pkt_start   (ip_start),
    .pkt_hdr_ok  (ip_hdr_valid),
    .pkt_proto   (ip_proto),
    .in_valid    (ip_data_valid),
    .in_last     (ip_data_last),
    .hdr_final   (hdr_final),
    .state_q     (state),
    .accept_udp  (accept_udp),
    .hdr_byte_en (hdr_byte_en),
    .pay_en      (pay_en),
    .pay_hold    (pay_hold),
    .hdr_clr     (hdr_clr)
  );

  udp_rx_hdr_cap #(
    .DW        (DW),
    .AW        (AW),
    .HDR_BYTES (HDR_BYTES)
  ) i_hdr_cap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_src  (accept_udp),
    .src_in    (ip_src_addr),
    .byte_en   (hdr_byte_en),
    .byte_in   (ip_data),
    .clr       (hdr_clr),
    .hdr_final (hdr_final),
    .hdr_valid (udp_hdr_valid),
    .src_port  (udp_src_port),
    .dst_port  (udp_dst_port),
    .pay_len   (udp_pay_len),
    .src_addr  (udp_src_addr)
  );

  udp_rx_fwd #(.DW(DW)) i_fwd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pay_en    (pay_en),
    .pay_hold  (pay_hold),
    .in_data   (ip_data),
    .in_last   (ip_data_last),
    .out_data  (udp_data),
    .out_valid (udp_data_valid),
    .out_last  (udp_data_last),
    .out_start (udp_start)
  );

  // R5: payload is never shown without a valid header
  p_data_needs_hdr_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    udp_data_valid |-> udp_hdr_valid);

  // R5: header valid only rises right after a header byte was taken
  p_hdr_rise_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(udp_hdr_valid) |-> $past(state == ST_HDR && ip_data_valid));

  // R2: a rejected packet leaves every output quiet
  p_drop_silent_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_DROP) |-> (!udp_hdr_valid && !udp_start && !udp_data_valid));

  // R11: a low packet strobe empties the outputs one cycle later
  p_start_low_clears_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ip_start |=> (!udp_hdr_valid && !udp_data_valid && !udp_start));
endmodule

// File: tb/test_udp_rx_parser.sv
`timescale 1ns/1ps
module test_udp_rx_parser;
  logic        clk;
  logic        rst_n;
  logic        ip_start, ip_hdr_valid, ip_data_valid, ip_data_last;
  logic [7:0]  ip_proto, ip_data;
  logic [31:0] ip_src_addr;
  logic        udp_start, udp_hdr_valid, udp_data_valid, udp_data_last;
  logic [15:0] udp_src_port, udp_dst_port, udp_pay_len;
  logic [31:0] udp_src_addr;
  logic [7:0]  udp_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  udp_rx_parser i_udp_rx_parser (
    .clk(clk), .rst_n(rst_n),
    .ip_start(ip_start), .ip_hdr_valid(ip_hdr_valid), .ip_proto(ip_proto),
    .ip_src_addr(ip_src_addr), .ip_data(ip_data), .ip_data_valid(ip_data_valid),
    .ip_data_last(ip_data_last),
    .udp_start(udp_start), .udp_hdr_valid(udp_hdr_valid),
    .udp_src_port(udp_src_port), .udp_dst_port(udp_dst_port),
    .udp_pay_len(udp_pay_len), .udp_src_addr(udp_src_addr),
    .udp_data(udp_data), .udp_data_valid(udp_data_valid), .udp_data_last(udp_data_last)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_len(input logic [15:0] u);
    return (u > 16'd8) ? (u - 16'd8) : 16'd0;
  endfunction

  task automatic quiet_outputs(input string tag);
    chk({tag, " data_valid"}, 32'(udp_data_valid), 32'd0);
    chk({tag, " data_last"},  32'(udp_data_last),  32'd0);
    chk({tag, " data"},       32'(udp_data),       32'd0);
    chk({tag, " start"},      32'(udp_start),      32'd0);
    chk({tag, " hdr_valid"},  32'(udp_hdr_valid),  32'd0);
  endtask

  // trunc_at: header index carrying last (-1 none); abort_at: payload index after which strobe drops
  task automatic run_pkt(input logic [7:0] proto, input logic [15:0] sp, input logic [15:0] dp,
                         input logic [15:0] ulen, input logic [31:0] src, input int npay,
                         input int trunc_at, input int gap_pct, input int abort_at);
    bit udp;
    bit started;
    logic [7:0] hb [8];
    int nbytes;
    logic [7:0] d;
    bit last;
    udp = (proto == 8'h11);
    started = 0;
    hb[0] = sp[15:8]; hb[1] = sp[7:0]; hb[2] = dp[15:8]; hb[3] = dp[7:0];
    hb[4] = ulen[15:8]; hb[5] = ulen[7:0];
    hb[6] = 8'($urandom); hb[7] = 8'($urandom);
    nbytes = (trunc_at >= 0) ? trunc_at + 1 : 8 + npay;
    ip_start = 1; ip_hdr_valid = 1; ip_proto = proto; ip_src_addr = src;
    ip_data_valid = 0; ip_data_last = 0;
    @(negedge clk);
    chk("R5 hdr_valid clear after accept", 32'(udp_hdr_valid), 32'd0);
    for (int i = 0; i < nbytes; i++) begin
      while (int'($urandom_range(99)) < gap_pct) begin
        ip_data_valid = 0;
        @(negedge clk);
        chk("R12 gap no byte", 32'(udp_data_valid), 32'd0);
        chk("R7 start across gap", 32'(udp_start), 32'(udp && started));
      end
      d = (i < 8) ? hb[i] : 8'($urandom);
      last = (i == nbytes - 1);
      ip_data_valid = 1; ip_data = d; ip_data_last = last;
      @(negedge clk);
      ip_data_valid = 0; ip_data_last = 0;
      if (i < 8) begin
        chk("R10 header byte not forwarded", 32'(udp_data_valid), 32'd0);
        chk("R5 R10 hdr_valid at header byte", 32'(udp_hdr_valid), 32'(udp && i == 7));
        if (udp && i == 7) begin
          chk("R3 src port", 32'(udp_src_port), 32'(sp));
          chk("R3 dst port", 32'(udp_dst_port), 32'(dp));
          chk("R4 payload length", 32'(udp_pay_len), 32'(exp_len(ulen)));
          chk("R6 src addr", 32'(udp_src_addr), src);
        end
      end else begin
        started = 1;
        chk("R7 data_valid", 32'(udp_data_valid), 32'(udp));
        chk("R7 data", 32'(udp_data), udp ? 32'(d) : 32'd0);
        chk("R8 data_last", 32'(udp_data_last), 32'(udp && last));
        chk("R7 start", 32'(udp_start), 32'(udp));
        chk("R5 hdr_valid through payload", 32'(udp_hdr_valid), 32'(udp));
        if (abort_at >= 0 && i == 8 + abort_at && !last) begin
          ip_start = 0; ip_hdr_valid = 0;
          @(negedge clk);
          quiet_outputs("R11 abort");
          @(negedge clk);
          return;
        end
      end
    end
    ip_start = 0; ip_hdr_valid = 0;
    @(negedge clk);
    quiet_outputs("R9 R11 end of packet");
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    rst_n = 0; ip_start = 0; ip_hdr_valid = 0; ip_proto = 0; ip_src_addr = 0;
    ip_data = 0; ip_data_valid = 0; ip_data_last = 0;
    repeat (4) @(negedge clk);
    quiet_outputs("R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    quiet_outputs("R1 after reset");

    run_pkt(8'h11, 16'h1498, 16'h8724, 16'h000b, 32'hc0a80501, 3, -1, 0, -1);
    run_pkt(8'h11, 16'h7623, 16'h0365, 16'h000d, 32'hc0a80501, 5, -1, 0, -1);
    run_pkt(8'h12, 16'h7623, 16'h0365, 16'h000d, 32'hc0a80501, 5, -1, 0, -1);   // R2
    run_pkt(8'h11, 16'h1498, 16'h8724, 16'h000b, 32'h0a000001, 3, -1, 0, -1);   // R11 after reject
    run_pkt(8'h11, 16'hbeef, 16'h0035, 16'h0010, 32'h01020304, 8, 3, 0, -1);    // R10 short header
    run_pkt(8'h11, 16'h0001, 16'hffff, 16'h0008, 32'hffffffff, 0, -1, 0, -1);   // R10 last on byte 7
    run_pkt(8'h11, 16'h1234, 16'h5678, 16'h0005, 32'h11223344, 2, -1, 0, -1);   // R4 saturate
    run_pkt(8'h11, 16'h4321, 16'h8765, 16'h0040, 32'h55667788, 2, -1, 0, -1);   // R4 field wins
    run_pkt(8'h11, 16'h0a0b, 16'h0c0d, 16'h0014, 32'h99aabbcc, 12, -1, 0, 4);   // R11 abort
    run_pkt(8'h11, 16'h2222, 16'h3333, 16'h000f, 32'hdeadbeef, 7, -1, 50, -1);  // R12 gaps
    run_pkt(8'h06, 16'h2222, 16'h3333, 16'h000f, 32'hdeadbeef, 7, -1, 40, -1);  // R2 gaps

    for (int k = 0; k < 80; k++) begin
      logic [7:0]  pr;
      logic [15:0] ul;
      int np, tr, ab;
      pr = ($urandom_range(9) < 7) ? 8'h11 : (8'($urandom) | 8'h20);
      np = int'($urandom_range(12));
      ul = ($urandom_range(3) == 0) ? 16'($urandom) : 16'(np + 8);
      tr = ($urandom_range(9) == 0) ? int'($urandom_range(7)) : -1;
      ab = (np > 1 && $urandom_range(9) == 0) ? int'($urandom_range(np - 2)) : -1;
      run_pkt(pr, 16'($urandom), 16'($urandom), ul, $urandom, np, tr,
              int'($urandom_range(1)) * 30, ab);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule